// File: doc/BRIEF.md
# Supervisory Watchdog and Reset Generator

This block drives the active-low system reset of a microcontroller. The reset has three causes. The first is power application, which this block sees as its own synchronous reset input. The second is a power-good level from an external supply comparator that goes low. The third is a watchdog timer that the software fails to restart in time. After any of these events, the reset output stays low for a hold-off period counted in clock cycles. This gives the supply and the oscillator time to settle before the processor runs.

Software keeps the watchdog alive by toggling the kick input. Either edge counts as a restart. The kick passes through a two-flop synchronizer before edge detection. A two-bit static selection picks one of three parameterised timeout lengths or switches the watchdog off. A volatile cause flag tells software whether the last reset came from the watchdog (1) or from low supply (0). The flag is cleared by power-up.

Top module: `supervisor_reset`

## Requirements
- R1: While `rst_n` is sampled low, `sys_rst_n` is 0 and `wd_cause` is 0 from the next clock edge onward.
- R2: After `rst_n` rises with `supply_ok` high, `sys_rst_n` goes high on the HOLD_CYC-th clock edge that samples both `rst_n` and `supply_ok` high.
- R3: Any edge that samples `supply_ok` low drives `sys_rst_n` to 0 and `wd_cause` to 0.
- R4: The hold-off restarts from zero every time `supply_ok` is sampled low. Release therefore needs HOLD_CYC consecutive edges with the supply good.
- R5: The watchdog interval is set by `wd_sel`: 2'b00 selects WD_INT0 cycles, 2'b01 selects WD_INT1 and 2'b10 selects WD_INT2. When no kick arrives, `sys_rst_n` stays high for exactly that many cycles after release, then falls with `wd_cause` set to 1.
- R6: `wd_sel` = 2'b11 disables the watchdog, so `sys_rst_n` never falls for lack of kicks.
- R7: Each rising or falling edge of `wd_kick` restarts the watchdog. Counting from the cycle the kick toggles, `sys_rst_n` stays high for the interval plus 3 cycles.
- R8: A watchdog timeout holds `sys_rst_n` low for exactly HOLD_CYC cycles. The next interval then starts from zero.
- R9: Kick edges that enter the synchronizer while reset is asserted have no effect. This holds when the kick toggles at least three cycles before release: the first interval after release is still the full interval.
- R10: `wd_cause` keeps its value while `sys_rst_n` stays high and through a watchdog hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| supply_ok | input | 1 | Power-good level from the external comparator |
| wd_kick | input | 1 | Watchdog restart; both edges count |
| wd_sel | input | 2 | Interval select: 00/01/10 intervals, 11 off |
| sys_rst_n | output | 1 | Active-low system reset |
| wd_cause | output | 1 | 1 = last reset from watchdog, 0 = from low supply |

## Verification
The assertions check the cycle-level rules on every cycle:
- Reset and a low supply force the output low and clear the flag.
- Release never follows a low-supply sample.
- A fall with good supply always carries the watchdog flag.
- The flag is stable while running.
- A disabled watchdog never causes a fall.

The exact lengths need the bench scenarios. These are the hold-off, each selectable interval, the kick latency through the synchronizer, and the hold-off restart on a supply dip. The same goes for kicks being ignored during reset.

// File: rtl/sup_rst_pkg.sv
// Shared types for the supervisory reset generator.
package sup_rst_pkg;
    // Watchdog interval selection codes.
    typedef enum logic [1:0] {
        WD_SEL_SHORT = 2'b00,
        WD_SEL_MID   = 2'b01,
        WD_SEL_LONG  = 2'b10,
        WD_SEL_OFF   = 2'b11
    } wd_sel_e;
endpackage

// File: rtl/kick_sync.sv
// Kick synchronizer and edge detector.
// Brings the asynchronous kick level through two flops and flags any
// change of the synchronized level (rising or falling) for one cycle.
// Assumes the kick stays stable for at least two clock cycles per level.
module kick_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_async,
    output logic kick_edge
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-flop synchronizer followed by a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= kick_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Either direction of change is a restart request.
    assign kick_edge = sync_q ^ prev_q;
endmodule

// File: rtl/wd_timer.sv
// Watchdog interval counter.
// Counts cycles while the system runs. A kick edge or an active system reset
// clears it. It raises expire on the last cycle of the selected interval.
// Assumes each interval parameter is at least 2 and fits in CNT_W bits.
module wd_timer
    import sup_rst_pkg::*;
#(
    parameter int unsigned WD_INT0 = 15_000_000,
    parameter int unsigned WD_INT1 = 60_000_000,
    parameter int unsigned WD_INT2 = 140_000_000,
    parameter int unsigned CNT_W   = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             holding,
    input  logic             kick_edge,
    input  logic [1:0]       sel,
    output logic             expire
);
    localparam logic [CNT_W-1:0] LAST0 = CNT_W'(WD_INT0 - 1);
    localparam logic [CNT_W-1:0] LAST1 = CNT_W'(WD_INT1 - 1);
    localparam logic [CNT_W-1:0] LAST2 = CNT_W'(WD_INT2 - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             enabled;

    // Decode the selection into a terminal count and an enable.
    always_comb begin
        enabled  = 1'b1;
        last_cnt = LAST0;
        case (wd_sel_e'(sel))
            WD_SEL_SHORT: last_cnt = LAST0;
            WD_SEL_MID:   last_cnt = LAST1;
            WD_SEL_LONG:  last_cnt = LAST2;
            default: begin
                enabled  = 1'b0;
                last_cnt = LAST0;
            end
        endcase
    end

    // Interval counter: cleared by reset, by hold-off and by kicks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (holding || kick_edge || !enabled) begin
            cnt_q <= '0;
        end else if (cnt_q != last_cnt) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Timeout when the terminal count is reached with no restart pending.
    assign expire = enabled && !holding && !kick_edge && (cnt_q == last_cnt);
endmodule

// File: rtl/holdoff_ctrl.sv
// Reset hold-off and cause tracking.
// Keeps the system in reset after power-up, a supply fault or a watchdog
// timeout until HOLD_CYC consecutive good-supply cycles have passed.
// It records whether the last reset came from the watchdog.
// Assumes HOLD_CYC >= 2.
module holdoff_ctrl #(
    parameter int unsigned HOLD_CYC = 10_000_000,
    parameter int unsigned HOLD_W   = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic wd_expire,
    output logic holding,
    output logic wd_cause
);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

    logic [HOLD_W-1:0] hold_cnt_q;
    logic              holding_q;
    logic              cause_q;

    // Hold-off sequencing: power-up and supply faults win over the watchdog.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holding_q  <= 1'b1;
            hold_cnt_q <= '0;
            cause_q    <= 1'b0;
        end else if (!supply_ok) begin
            holding_q  <= 1'b1;
            hold_cnt_q <= '0;
            cause_q    <= 1'b0;
        end else if (holding_q) begin
            if (hold_cnt_q == HOLD_LAST) begin
                holding_q  <= 1'b0;
                hold_cnt_q <= '0;
            end else begin
                hold_cnt_q <= hold_cnt_q + 1'b1;
            end
        end else if (wd_expire) begin
            holding_q <= 1'b1;
            cause_q   <= 1'b1;
        end
    end

    assign holding  = holding_q;
    assign wd_cause = cause_q;
endmodule

// File: rtl/supervisor_reset.sv
// Supervisory reset generator top level.
// Combines the power-on hold-off, the supply-fail reset and an edge-restarted
// watchdog into one active-low system reset with a cause flag.
// Assumes wd_sel is static while the system runs.
module supervisor_reset #(
    parameter int unsigned HOLD_CYC = 10_000_000,
    parameter int unsigned WD_INT0  = 15_000_000,
    parameter int unsigned WD_INT1  = 60_000_000,
    parameter int unsigned WD_INT2  = 140_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       wd_kick,
    input  logic [1:0] wd_sel,
    output logic       sys_rst_n,
    output logic       wd_cause
);
    localparam int unsigned WD_MAX01 = (WD_INT0 > WD_INT1) ? WD_INT0 : WD_INT1;
    localparam int unsigned WD_MAX   = (WD_MAX01 > WD_INT2) ? WD_MAX01 : WD_INT2;
    localparam int unsigned CNT_W    = $clog2(WD_MAX + 1);
    localparam int unsigned HOLD_W   = $clog2(HOLD_CYC + 1);

    logic kick_edge;
    logic holding;
    logic wd_expire;

    kick_sync u_kick (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick_async (wd_kick),
        .kick_edge  (kick_edge)
    );

    wd_timer #(
        .WD_INT0 (WD_INT0),
        .WD_INT1 (WD_INT1),
        .WD_INT2 (WD_INT2),
        .CNT_W   (CNT_W)
    ) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .holding   (holding),
        .kick_edge (kick_edge),
        .sel       (wd_sel),
        .expire    (wd_expire)
    );

    holdoff_ctrl #(
        .HOLD_CYC (HOLD_CYC),
        .HOLD_W   (HOLD_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .wd_expire (wd_expire),
        .holding   (holding),
        .wd_cause  (wd_cause)
    );

    assign sys_rst_n = ~holding;
endmodule

// File: rtl/supervisor_reset_chk.sv
// Protocol checker for the supervisory reset generator. It is bound to the top.
module supervisor_reset_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic [1:0] wd_sel,
    input logic       sys_rst_n,
    input logic       wd_cause
);
    // R1: power-on reset forces reset out and clears the cause.
    p_por_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!sys_rst_n && !wd_cause));

    // R3: a low supply sample asserts reset with the low-voltage cause.
    p_supply_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!sys_rst_n && !wd_cause));

    // R4: release never directly follows a low supply sample.
    p_release_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> $past(supply_ok));

    // R5: a fall with good supply is a watchdog reset.
    p_wd_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sys_rst_n) && $past(supply_ok)) |-> wd_cause);

    // R6: a disabled watchdog never ends a running period.
    p_wd_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_n && supply_ok && wd_sel == 2'b11) |=> sys_rst_n);

    // R10: the cause flag is stable while the system runs.
    p_cause_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_n && $past(sys_rst_n)) |-> $stable(wd_cause));
endmodule

bind supervisor_reset supervisor_reset_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .wd_sel    (wd_sel),
    .sys_rst_n (sys_rst_n),
    .wd_cause  (wd_cause)
);

// File: tb/supervisor_reset_tb_top.sv
// Self-checking bench: sweeps every selection code and kick direction.
module supervisor_reset_tb_top;
    localparam int HOLD = 20;
    localparam int I0   = 30;
    localparam int I1   = 50;
    localparam int I2   = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b1;
    logic       wd_kick = 1'b0;
    logic [1:0] wd_sel = 2'b00;
    logic       sys_rst_n;
    logic       wd_cause;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    supervisor_reset #(
        .HOLD_CYC (HOLD), .WD_INT0 (I0), .WD_INT1 (I1), .WD_INT2 (I2)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .supply_ok (supply_ok), .wd_kick (wd_kick),
        .wd_sel (wd_sel), .sys_rst_n (sys_rst_n), .wd_cause (wd_cause)
    );

    function automatic int lim_of(input int s);
        case (s)
            0: return I0;
            1: return I1;
            default: return I2;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count consecutive negedge samples (current one included) at the given level.
    task automatic run_len(input logic lvl, input int max, output int n);
        n = 0;
        while (sys_rst_n == lvl && n < max) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Apply power-on reset, set the selection, release at a negedge.
    task automatic power_up(input logic [1:0] sel);
        rst_n = 1'b0;
        supply_ok = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset out", int'(sys_rst_n), 0);
        chk("R1 cause", int'(wd_cause), 0);
        wd_sel = sel;
        rst_n = 1'b1;
    endtask

    initial begin
        int n;
        @(negedge clk);
        // R1/R2: power-up state and hold-off length.
        power_up(2'b00);
        run_len(1'b0, 1000, n);
        chk("R2 hold-off", n, HOLD);

        // R5/R8: every interval, then a full hold-off and a fresh interval.
        for (int s = 0; s < 3; s++) begin
            power_up(2'(s));
            run_len(1'b0, 1000, n);
            chk("R2 hold-off", n, HOLD);
            run_len(1'b1, 1000, n);
            chk("R5 interval", n, lim_of(s));
            chk("R5 cause", int'(wd_cause), 1);
            run_len(1'b0, 1000, n);
            chk("R8 wd hold-off", n, HOLD);
            chk("R10 cause kept", int'(wd_cause), 1);
            run_len(1'b1, 1000, n);
            chk("R8 interval restart", n, lim_of(s));
        end

        // R6: disabled watchdog never fires.
        power_up(2'b11);
        run_len(1'b0, 1000, n);
        run_len(1'b1, 4 * I2, n);
        chk("R6 disabled", n, 4 * I2);

        // R7: kick latency for both edge directions, and keep-alive.
        for (int s = 0; s < 3; s++) begin
            for (int d = 0; d < 2; d++) begin
                power_up(2'(s));
                run_len(1'b0, 1000, n);
                repeat (5) @(negedge clk);
                wd_kick = ~wd_kick;
                run_len(1'b1, 1000, n);
                chk(d == 0 ? "R7 kick edge a" : "R7 kick edge b", n, lim_of(s) + 3);
            end
            power_up(2'(s));
            run_len(1'b0, 1000, n);
            begin
                int lows = 0;
                for (int k = 0; k < 8 * lim_of(s); k++) begin
                    if (k % (lim_of(s) / 2) == 0) wd_kick = ~wd_kick;
                    if (!sys_rst_n) lows++;
                    @(negedge clk);
                end
                chk("R7 keep-alive", lows, 0);
            end
        end

        // R9: kicks during hold-off are ignored.
        power_up(2'b00);
        for (int i = 0; i < HOLD - 6; i++) begin
            if (i % 2 == 0) wd_kick = ~wd_kick;
            @(negedge clk);
        end
        run_len(1'b0, 1000, n);
        chk("R9 hold rest", n, 6);
        run_len(1'b1, 1000, n);
        chk("R9 interval", n, I0);

        // R3/R4: supply fault after a watchdog reset, then a dip during hold-off.
        chk("R10 cause before fault", int'(wd_cause), 1);
        run_len(1'b0, 1000, n);
        repeat (3) @(negedge clk);
        chk("R3 running", int'(sys_rst_n), 1);
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R3 reset out", int'(sys_rst_n), 0);
        chk("R3 cause", int'(wd_cause), 0);
        repeat (4) @(negedge clk);
        supply_ok = 1'b1;
        run_len(1'b0, 1000, n);
        chk("R4 hold after fault", n, HOLD);
        wd_sel = 2'b11;
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        repeat (10) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        run_len(1'b0, 1000, n);
        chk("R4 dip restarts", n, HOLD);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule